// File: doc/BRIEF.md
# CAM with Bitmap-Table Fallback Matcher

The block holds a table of 32-bit keys, each with its own validity bit. Next to it is a one-bit-per-index lookup bitmap addressed by a 12-bit path identifier. When a compare strobe arrives, the block searches every valid CAM entry in parallel for the compare word. In the same cycle it reads the bitmap at the identifier ANDed with a configuration mask. The outcome is registered and shown on two active-low flags, a 12-bit match address and a 4-bit page bus. A CAM hit always wins over the bitmap. A bitmap hit is reported only when the CAM misses, and the two cases are told apart by the pair of flags.

A cascade input allows several devices to be chained. When the input is low, a device of higher priority has already found a CAM hit, and this device reports the cascade code instead of its own result. CAM words and bitmap bits are loaded and read back through plain address/data ports. The compare mask has no effect on those direct accesses. The CAM depth must be a power of two, and the CAM address must fit in the 12-bit match bus.

Top module: `cam_vp_match`

## Requirements
- R1: After reset, mv_n_o=1, mf_n_o=1, match_addr_o=0 and page_o=0. Every CAM entry reads back as invalid (cam_rvalid_o=0) and every bitmap bit reads back as 1.
- R2: A CAM write stores cam_wdata_i and cam_wvalid_i at cam_addr_i. A read (cam_re_i) presents the stored word and validity bit on cam_rdata_o/cam_rvalid_o one clock later.
- R3: A bitmap write stores tbl_wbit_i at tbl_addr_i. A read (tbl_re_i) presents that bit on tbl_rbit_o one clock later. A bit value of 0 means match and 1 means mismatch.
- R4: The compare result appears on the outputs one clock after cmp_stb_i. Only entries whose validity bit is 1 take part. On a CAM hit the flags are mv_n_o=0, mf_n_o=0, match_addr_o is the zero-extended entry index and page_o=0.
- R5: When several valid entries match, the lowest index is reported.
- R6: On a CAM miss, if the bitmap bit at (vpi_i & vpi_mask_i) is 0, the flags are mv_n_o=0 and mf_n_o=1. match_addr_o then carries the masked identifier and page_o carries page_cfg_i.
- R7: A CAM hit is reported unchanged whatever the bitmap bit at the masked index holds.
- R8: On a miss in both the CAM and the bitmap, mv_n_o=1, mf_n_o=1, match_addr_o=0 and page_o=0.
- R9: When casc_mi_n_i is low during a compare, the flags are mv_n_o=1 and mf_n_o=0, with match_addr_o=0 and page_o=0, even if this device has a hit of its own.
- R10: vpi_vpi_mask_i applies only to compare lookups. Direct bitmap reads and writes use the full 12-bit tbl_addr_i.
- R11: Without a compare strobe, all four result outputs keep their values.
- R12: A compare issued in the same cycle as a CAM or bitmap write uses the contents as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_stb_i | input | 1 | Compare strobe |
| cmp_data_i | input | 32 | Compare key |
| vpi_i | input | 12 | Path identifier for bitmap lookup |
| vpi_mask_i | input | 12 | Mask ANDed into the identifier on compares |
| page_cfg_i | input | 4 | Page value reported on a bitmap hit |
| casc_mi_n_i | input | 1 | Cascade match-in, low = higher device hit |
| cam_we_i | input | 1 | CAM write enable |
| cam_re_i | input | 1 | CAM read enable |
| cam_addr_i | input | 6 | CAM entry address |
| cam_wdata_i | input | 32 | CAM write word |
| cam_wvalid_i | input | 1 | Validity bit to write |
| cam_rdata_o | output | 32 | CAM read word |
| cam_rvalid_o | output | 1 | CAM read validity bit |
| tbl_we_i | input | 1 | Bitmap write enable |
| tbl_re_i | input | 1 | Bitmap read enable |
| tbl_addr_i | input | 12 | Bitmap direct address (unmasked) |
| tbl_wbit_i | input | 1 | Bitmap bit to write |
| tbl_rbit_o | output | 1 | Bitmap read bit |
| mv_n_o | output | 1 | Match-valid flag, active low |
| mf_n_o | output | 1 | Match-full flag, active low |
| match_addr_o | output | 12 | CAM index or masked identifier |
| page_o | output | 4 | Page bus |

## Verification
Two functions can fall in the same cycle: a compare and a write that changes the entry or bitmap bit the compare depends on. The bench provokes this in two ways. First, it strobes a compare that hits CAM entry 3 while clearing that entry's validity bit. Second, it strobes a compare that relies on a bitmap 0 while writing 1 to that bit. The compare in each collision cycle must report the old contents. A compare repeated straight afterwards must show the new contents, so the bench confirms both that the write took effect and that the collision saw the pre-write state.

// File: rtl/cvm_pkg.sv
package cvm_pkg;

  // Flag code, packed as {mv_n, mf_n}
  typedef enum logic [1:0] {
    FLG_CAM  = 2'b00,
    FLG_TBL  = 2'b01,
    FLG_CASC = 2'b10,
    FLG_NONE = 2'b11
  } flg_t;

  // Priority order: cascade, then own CAM hit, then bitmap hit
  function automatic flg_t resolve_flags(input logic casc_n,
                                         input logic cam_hit,
                                         input logic tbl_hit);
    if (!casc_n)      return FLG_CASC;
    else if (cam_hit) return FLG_CAM;
    else if (tbl_hit) return FLG_TBL;
    else              return FLG_NONE;
  endfunction

endpackage

// File: rtl/cvm_cam_array.sv
module cvm_cam_array #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wvalid,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid,
  input  logic [DATA_W-1:0]        key,
  output logic [DEPTH-1:0]         hit_vec
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld <= '0;
    else if (we) vld[addr] <= wvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (re) begin
      rdata  <= mem[addr];
      rvalid <= vld[addr];
    end
  end

  // Parallel compare over all entries, gated by validity
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (mem[g] == key);
  end

  logic unused_aw;
  assign unused_aw = (AW == 0);
endmodule

// File: rtl/cvm_prio_enc.sv
module cvm_prio_enc #(
  parameter int N = 64
) (
  input  logic [N-1:0]         vec,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/cvm_vp_table.sv
module cvm_vp_table #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] addr,
  input  logic             wbit,
  output logic             rbit,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [IDX_W-1:0] look_mask,
  output logic [IDX_W-1:0] look_masked,
  output logic             look_hit
);
  localparam int N = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] mask_index(input logic [IDX_W-1:0] id,
                                                  input logic [IDX_W-1:0] m);
    return id & m;
  endfunction

  logic [N-1:0] bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bits <= '1;
    else if (we) bits[addr] <= wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rbit <= 1'b1;
    else if (re) rbit <= bits[addr];
  end

  assign look_masked = mask_index(look_idx, look_mask);
  assign look_hit    = ~bits[look_masked];   // 0 in the bitmap means match
endmodule

// File: rtl/cam_vp_match.sv
module cam_vp_match #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int VPI_W  = 12,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_stb_i,
  input  logic [DATA_W-1:0]        cmp_data_i,
  input  logic [VPI_W-1:0]         vpi_i,
  input  logic [VPI_W-1:0]         vpi_mask_i,
  input  logic [PAGE_W-1:0]        page_cfg_i,
  input  logic                     casc_mi_n_i,
  input  logic                     cam_we_i,
  input  logic                     cam_re_i,
  input  logic [$clog2(DEPTH)-1:0] cam_addr_i,
  input  logic [DATA_W-1:0]        cam_wdata_i,
  input  logic                     cam_wvalid_i,
  output logic [DATA_W-1:0]        cam_rdata_o,
  output logic                     cam_rvalid_o,
  input  logic                     tbl_we_i,
  input  logic                     tbl_re_i,
  input  logic [VPI_W-1:0]         tbl_addr_i,
  input  logic                     tbl_wbit_i,
  output logic                     tbl_rbit_o,
  output logic                     mv_n_o,
  output logic                     mf_n_o,
  output logic [VPI_W-1:0]         match_addr_o,
  output logic [PAGE_W-1:0]        page_o
);
  import cvm_pkg::*;

  localparam int CAM_AW = $clog2(DEPTH);

  // Named internal events
  logic [DEPTH-1:0]  cam_hit_vec_w;
  logic              cam_any_w;
  logic [CAM_AW-1:0] cam_idx_w;
  logic              tbl_hit_w;
  logic [VPI_W-1:0]  tbl_idx_w;
  flg_t              code_w;
  logic [VPI_W-1:0]  addr_nxt_w;
  logic [PAGE_W-1:0] page_nxt_w;

  cvm_cam_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_cam (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cam_we_i),
    .re     (cam_re_i),
    .addr   (cam_addr_i),
    .wdata  (cam_wdata_i),
    .wvalid (cam_wvalid_i),
    .rdata  (cam_rdata_o),
    .rvalid (cam_rvalid_o),
    .key    (cmp_data_i),
    .hit_vec(cam_hit_vec_w)
  );

  cvm_prio_enc #(.N(DEPTH)) i_prio (
    .vec(cam_hit_vec_w),
    .any(cam_any_w),
    .idx(cam_idx_w)
  );

  cvm_vp_table #(.IDX_W(VPI_W)) i_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (tbl_we_i),
    .re         (tbl_re_i),
    .addr       (tbl_addr_i),
    .wbit       (tbl_wbit_i),
    .rbit       (tbl_rbit_o),
    .look_idx   (vpi_i),
    .look_mask  (vpi_mask_i),
    .look_masked(tbl_idx_w),
    .look_hit   (tbl_hit_w)
  );

  assign code_w = resolve_flags(casc_mi_n_i, cam_any_w, tbl_hit_w);

  always_comb begin
    addr_nxt_w = '0;
    page_nxt_w = '0;
    case (code_w)
      FLG_CAM: addr_nxt_w = VPI_W'(cam_idx_w);
      FLG_TBL: begin
        addr_nxt_w = tbl_idx_w;
        page_nxt_w = page_cfg_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_n_o       <= 1'b1;
      mf_n_o       <= 1'b1;
      match_addr_o <= '0;
      page_o       <= '0;
    end else if (cmp_stb_i) begin
      {mv_n_o, mf_n_o} <= code_w;
      match_addr_o     <= addr_nxt_w;
      page_o           <= page_nxt_w;
    end
  end
endmodule

// File: rtl/cvm_match_chk.sv
module cvm_match_chk #(
  parameter int VPI_W  = 12,
  parameter int PAGE_W = 4,
  parameter int CAM_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_stb_i,
  input logic              casc_mi_n_i,
  input logic [VPI_W-1:0]  vpi_i,
  input logic [VPI_W-1:0]  vpi_mask_i,
  input logic [PAGE_W-1:0] page_cfg_i,
  input logic              cam_any_w,
  input logic [CAM_AW-1:0] cam_idx_w,
  input logic              tbl_hit_w,
  input logic              mv_n_o,
  input logic              mf_n_o,
  input logic [VPI_W-1:0]  match_addr_o,
  input logic [PAGE_W-1:0] page_o
);
  assert_cam_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb_i && casc_mi_n_i && cam_any_w) |=>
      (!mv_n_o && !mf_n_o && match_addr_o == VPI_W'($past(cam_idx_w)) && page_o == '0));

  assert_tbl_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb_i && casc_mi_n_i && !cam_any_w && tbl_hit_w) |=>
      (!mv_n_o && mf_n_o && match_addr_o == ($past(vpi_i) & $past(vpi_mask_i))
       && page_o == $past(page_cfg_i)));

  assert_double_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb_i && casc_mi_n_i && !cam_any_w && !tbl_hit_w) |=>
      (mv_n_o && mf_n_o && match_addr_o == '0));

  assert_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_stb_i && !casc_mi_n_i) |=> (mv_n_o && !mf_n_o && page_o == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_stb_i |=> $stable({mv_n_o, mf_n_o, match_addr_o, page_o}));
endmodule

bind cam_vp_match cvm_match_chk #(.VPI_W(VPI_W), .PAGE_W(PAGE_W), .CAM_AW(CAM_AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_stb_i   (cmp_stb_i),
  .casc_mi_n_i (casc_mi_n_i),
  .vpi_i       (vpi_i),
  .vpi_mask_i  (vpi_mask_i),
  .page_cfg_i  (page_cfg_i),
  .cam_any_w   (cam_any_w),
  .cam_idx_w   (cam_idx_w),
  .tbl_hit_w   (tbl_hit_w),
  .mv_n_o      (mv_n_o),
  .mf_n_o      (mf_n_o),
  .match_addr_o(match_addr_o),
  .page_o      (page_o)
);

// File: tb/test_cam_vp_match.sv
module test_cam_vp_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_stb_i = 1'b0;
  logic [31:0] cmp_data_i = '0;
  logic [11:0] vpi_i = '0;
  logic [11:0] vpi_mask_i = '1;
  logic [3:0]  page_cfg_i = '0;
  logic        casc_mi_n_i = 1'b1;
  logic        cam_we_i = 1'b0;
  logic        cam_re_i = 1'b0;
  logic [5:0]  cam_addr_i = '0;
  logic [31:0] cam_wdata_i = '0;
  logic        cam_wvalid_i = 1'b0;
  logic [31:0] cam_rdata_o;
  logic        cam_rvalid_o;
  logic        tbl_we_i = 1'b0;
  logic        tbl_re_i = 1'b0;
  logic [11:0] tbl_addr_i = '0;
  logic        tbl_wbit_i = 1'b0;
  logic        tbl_rbit_o;
  logic        mv_n_o;
  logic        mf_n_o;
  logic [11:0] match_addr_o;
  logic [3:0]  page_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  cam_vp_match i_cam_vp_match (.*);

  typedef struct packed {
    logic [31:0] data;
    logic [11:0] vpi;
    logic [11:0] mask;
    logic        casc;
    logic [3:0]  page;
    logic [3:0]  req;
    logic        emv;
    logic        emf;
    logic [11:0] eaddr;
    logic [3:0]  epage;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'hDEADBEEF, 12'h000, 12'hFFF, 1'b1, 4'h5, 4'd4,  1'b0, 1'b0, 12'h003, 4'h0}, // R4 hit entry 3
    '{32'h12345678, 12'h000, 12'hFFF, 1'b1, 4'h5, 4'd5,  1'b0, 1'b0, 12'h005, 4'h0}, // R5 entries 5 and 9
    '{32'hCAFEF00D, 12'h111, 12'hFFF, 1'b1, 4'h5, 4'd8,  1'b1, 1'b1, 12'h000, 4'h0}, // R8 invalid entry, bit 1
    '{32'h00000001, 12'h0A5, 12'hFFF, 1'b1, 4'h9, 4'd6,  1'b0, 1'b1, 12'h0A5, 4'h9}, // R6 bitmap hit
    '{32'h00000001, 12'hFA5, 12'h0FF, 1'b1, 4'h2, 4'd10, 1'b0, 1'b1, 12'h0A5, 4'h2}, // R10 mask narrows id
    '{32'hDEADBEEF, 12'h0A5, 12'hFFF, 1'b1, 4'h2, 4'd7,  1'b0, 1'b0, 12'h003, 4'h0}, // R7 CAM beats bitmap
    '{32'hDEADBEEF, 12'h0A5, 12'hFFF, 1'b0, 4'h2, 4'd9,  1'b1, 1'b0, 12'h000, 4'h0}, // R9 cascade
    '{32'h00000002, 12'h3C1, 12'h0FF, 1'b1, 4'h3, 4'd10, 1'b1, 1'b1, 12'h000, 4'h0}, // R10 0x0C1 is 1
    '{32'h00000002, 12'h3C1, 12'hFFF, 1'b1, 4'h3, 4'd3,  1'b0, 1'b1, 12'h3C1, 4'h3}  // R3 unmasked write
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cam_wr(input logic [5:0] a, input logic [31:0] d, input logic v);
    @(negedge clk);
    cam_we_i = 1; cam_addr_i = a; cam_wdata_i = d; cam_wvalid_i = v;
    @(negedge clk);
    cam_we_i = 0;
  endtask

  task automatic tbl_wr(input logic [11:0] a, input logic b);
    @(negedge clk);
    tbl_we_i = 1; tbl_addr_i = a; tbl_wbit_i = b;
    @(negedge clk);
    tbl_we_i = 0;
  endtask

  task automatic cam_rd(input logic [5:0] a);
    @(negedge clk);
    cam_re_i = 1; cam_addr_i = a;
    @(negedge clk);
    cam_re_i = 0;
  endtask

  task automatic tbl_rd(input logic [11:0] a);
    @(negedge clk);
    tbl_re_i = 1; tbl_addr_i = a;
    @(negedge clk);
    tbl_re_i = 0;
  endtask

  // Drives a compare; returns at the negedge after the registering edge
  task automatic cmp(input logic [31:0] d, input logic [11:0] v, input logic [11:0] m,
                     input logic c, input logic [3:0] p);
    @(negedge clk);
    cmp_stb_i = 1; cmp_data_i = d; vpi_i = v; vpi_mask_i = m; casc_mi_n_i = c; page_cfg_i = p;
    @(negedge clk);
    cmp_stb_i = 0; casc_mi_n_i = 1;
  endtask

  function automatic logic [17:0] res();
    return {mv_n_o, mf_n_o, match_addr_o, page_o};
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 flags/addr/page", 64'(res()), 64'({1'b1, 1'b1, 12'h000, 4'h0}));
    cam_rd(6'd3);
    chk("R1 entry invalid", 64'(cam_rvalid_o), 64'd0);
    tbl_rd(12'h0A5);
    chk("R1 bitmap bit is 1", 64'(tbl_rbit_o), 64'd1);

    // Setup
    cam_wr(6'd3, 32'hDEADBEEF, 1);
    cam_wr(6'd5, 32'h12345678, 1);
    cam_wr(6'd9, 32'h12345678, 1);
    cam_wr(6'd7, 32'hCAFEF00D, 0);
    tbl_wr(12'h0A5, 0);
    tbl_wr(12'h3C1, 0);

    // R2 read-back
    cam_rd(6'd5);
    chk("R2 rdata", 64'(cam_rdata_o), 64'h12345678);
    chk("R2 rvalid", 64'(cam_rvalid_o), 64'd1);
    cam_rd(6'd7);
    chk("R2 stored invalid", 64'(cam_rvalid_o), 64'd0);
    // R3 and R10 unmasked direct access
    tbl_rd(12'h3C1);
    chk("R3 bitmap read 0x3C1", 64'(tbl_rbit_o), 64'd0);
    tbl_rd(12'h0C1);
    chk("R10 bitmap read 0x0C1", 64'(tbl_rbit_o), 64'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      cmp(VEC[i].data, VEC[i].vpi, VEC[i].mask, VEC[i].casc, VEC[i].page);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(res()),
          64'({VEC[i].emv, VEC[i].emf, VEC[i].eaddr, VEC[i].epage}));
    end

    // R11 hold without strobe while inputs move
    held = res();
    @(negedge clk);
    cmp_data_i = 32'hDEADBEEF; vpi_i = 12'h0A5; page_cfg_i = 4'hF;
    repeat (3) @(negedge clk);
    chk("R11 outputs held", 64'(res()), 64'(held));

    // R12 compare and CAM write to the same entry in one cycle
    @(negedge clk);
    cmp_stb_i = 1; cmp_data_i = 32'hDEADBEEF; vpi_i = 12'h111; vpi_mask_i = '1; casc_mi_n_i = 1;
    cam_we_i = 1; cam_addr_i = 6'd3; cam_wdata_i = 32'hDEADBEEF; cam_wvalid_i = 0;
    @(negedge clk);
    cmp_stb_i = 0; cam_we_i = 0;
    chk("R12 CAM collision old", 64'(res()), 64'({1'b0, 1'b0, 12'h003, 4'h0}));
    cmp(32'hDEADBEEF, 12'h111, 12'hFFF, 1, 4'h0);
    chk("R12 CAM write applied", 64'(res()), 64'({1'b1, 1'b1, 12'h000, 4'h0}));

    // R12 compare and bitmap write to the same bit in one cycle
    @(negedge clk);
    cmp_stb_i = 1; cmp_data_i = 32'h00000007; vpi_i = 12'h0A5; vpi_mask_i = '1; page_cfg_i = 4'h6;
    tbl_we_i = 1; tbl_addr_i = 12'h0A5; tbl_wbit_i = 1;
    @(negedge clk);
    cmp_stb_i = 0; tbl_we_i = 0;
    chk("R12 bitmap collision old", 64'(res()), 64'({1'b0, 1'b1, 12'h0A5, 4'h6}));
    cmp(32'h00000007, 12'h0A5, 12'hFFF, 1, 4'h6);
    chk("R12 bitmap write applied", 64'(res()), 64'({1'b1, 1'b1, 12'h000, 4'h0}));

    // R5 lowest index after the lower duplicate is removed
    cam_wr(6'd5, 32'h12345678, 0);
    cmp(32'h12345678, 12'h000, 12'hFFF, 1, 4'h0);
    chk("R5 next duplicate", 64'(res()), 64'({1'b0, 1'b0, 12'h009, 4'h0}));

    // R1 reset mid-run returns outputs to idle
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset again", 64'(res()), 64'({1'b1, 1'b1, 12'h000, 4'h0}));
    rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule